// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives PCM audio as a slave on a set of serial data lines that share one bit clock and one left/right clock. It never drives either clock. Each data line carries a left/right pair, so the default three lines give six channels. A 3-bit mode code selects the framing and the word length together. Four framings are supported: right-justified, I2S, left-justified and a DSP-style frame with a one-bit sync pulse. Samples arrive MSB first in two's complement. Each one is sign-extended to the output width, and all channels are published together with a single valid pulse once per frame.

The bit clock, left/right clock and data lines are oversampled in the block clock domain, and a rising bit-clock edge marks each bit. A slot counter restarts at each frame marker. The format decides which slot closes a word. Any change of the mode code discards the frame in progress and mutes the outputs. The block then resynchronizes to the left/right clock before it publishes again. Reset enters the same recovery state.

Top module: `sar_rx`

## Requirements
- R1: While reset is applied and afterwards, `valid_o` is low and every sample reads zero until recovery ends. Reset starts the same recovery as a mode change, so no valid pulse appears during the first two frames after reset.
- R2: The mode code maps as follows. 0, 1 and 2 are right-justified with 16, 20 and 24 bits. 3, 4 and 5 are I2S with 16, 20 and 24 bits. 6 is left-justified with 24 bits. 7 is the DSP frame with 16 bits.
- R3: Left-justified: the MSB is the bit on the first rising bit-clock edge after a left/right clock change. Left/right clock low means left and high means right.
- R4: I2S: the MSB is the bit one bit-clock period after each left/right clock change. Left/right clock low means left and high means right.
- R5: Right-justified: the sample is the last N bits received before a left/right clock change. It belongs to the half that change ends, with low meaning left.
- R6: DSP frame: the left/right clock is high for exactly one bit to mark a frame. The left MSB arrives on the next bit, then 16 left bits and 16 right bits follow back to back.
- R7: Bits outside the word within a half-frame (padding, trailing and leading positions) do not change any captured sample.
- R8: Each sample is sign-extended from its word length to 24 bits.
- R9: `valid_o` is a one-cycle pulse, raised once per frame after both channels of every line are captured. Channel 2k is the left and 2k+1 the right of data line k, at bits [c*24 +: 24]. Between pulses the samples hold.
- R10: `valid_o` rises exactly 3 block-clock cycles after the rising bit-clock edge that carries the frame's closing bit. The bit clock and the left/right clock must hold each level for at least 2 block-clock cycles.
- R11: A mode code change zeroes the samples and drops `valid_o` on the next clock edge. Output stays muted until three rising left/right clock edges (two full periods) have passed. The first pulse after that comes from a frame whose left word starts after recovery.
- R12: Bit clocks of 48 and 64 times the sample rate work, giving 24 or 32 bits per half-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples the serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Format and word-length code |
| bclk_i | input | 1 | Serial bit clock, data taken on its rising edge |
| lrclk_i | input | 1 | Left/right clock or frame sync |
| sdata_i | input | LANES (3) | Serial data lines, one channel pair each |
| sample_o | output | 2*LANES*OUT_W (144) | All channels, channel c at [c*OUT_W +: OUT_W] |
| valid_o | output | 1 | One-cycle pulse when a full frame is published |

## Verification
The closing bit of a frame is registered by the input stage, captured by the lane on the following edge and published one edge later. So `valid_o` and the new samples are due on the third block-clock edge after the bench raises the bit clock for that bit. The bench raises the bit clock on a falling block-clock edge and looks one nanosecond after the second rising edge, expecting no pulse. It looks again after the third edge, expecting the pulse and the samples, and after the fourth, expecting the pulse gone. Muting after a mode change is checked after the first rising edge. The recovery window is measured in whole frames by counting pulses.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      FMT_RJ  = 2'd0,
      FMT_I2S = 2'd1,
      FMT_LJ  = 2'd2,
      FMT_DSP = 2'd3
   } fmt_e;

   typedef struct packed {
      fmt_e       fmt;
      logic [4:0] wlen;
   } cfg_t;

   localparam int unsigned MAX_WORD = 24;

   // Joint framing / word-length decode (R2)
   function automatic cfg_t decode_mode(input logic [2:0] code);
      cfg_t c;
      case (code)
         3'd0:    c = '{fmt: FMT_RJ,  wlen: 5'd16};
         3'd1:    c = '{fmt: FMT_RJ,  wlen: 5'd20};
         3'd2:    c = '{fmt: FMT_RJ,  wlen: 5'd24};
         3'd3:    c = '{fmt: FMT_I2S, wlen: 5'd16};
         3'd4:    c = '{fmt: FMT_I2S, wlen: 5'd20};
         3'd5:    c = '{fmt: FMT_I2S, wlen: 5'd24};
         3'd6:    c = '{fmt: FMT_LJ,  wlen: 5'd24};
         default: c = '{fmt: FMT_DSP, wlen: 5'd16};
      endcase
      return c;
   endfunction

endpackage

// File: rtl/sar_edge.sv
module sar_edge #(
   parameter int LANES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bclk_i,
   input  logic             lrclk_i,
   input  logic [LANES-1:0] sdata_i,
   output logic             bit_stb,
   output logic             lr_bit,
   output logic [LANES-1:0] dat_bit
);

   logic bclk_r, bclk_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bclk_r  <= 1'b0;
         bclk_d  <= 1'b0;
         lr_bit  <= 1'b0;
         dat_bit <= '0;
      end else begin
         bclk_r  <= bclk_i;
         bclk_d  <= bclk_r;
         lr_bit  <= lrclk_i;
         dat_bit <= sdata_i;
      end
   end

   assign bit_stb = bclk_r & ~bclk_d;

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
   import sar_pkg::*;
#(
   parameter int SLOT_W = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_stb,
   input  logic lr_bit,
   input  cfg_t cfg,
   input  logic mode_chg,
   output logic cap_en,
   output logic cap_right,
   output logic cap_old,
   output logic frame_done,
   output logic busy_o
);

   localparam logic [SLOT_W-1:0] SLOT_MAX    = '1;
   localparam int                RISES_NEED  = 3;
   localparam int                RCNT_W      = $clog2(RISES_NEED);

   logic              lr_prev, synced, left_seen;
   logic [SLOT_W-1:0] idx_q, slot, wl_s, wl2_s;
   logic [RCNT_W-1:0] rise_cnt;
   logic              lr_rise, lr_any, marker;
   logic              hit, right, old;

   assign lr_rise = bit_stb & lr_bit & ~lr_prev;
   assign lr_any  = bit_stb & (lr_bit ^ lr_prev);
   assign marker  = (cfg.fmt == FMT_DSP) ? lr_rise : lr_any;
   assign wl_s    = SLOT_W'(cfg.wlen);
   assign wl2_s   = wl_s << 1;

   always_comb begin
      if (marker)                slot = '0;
      else if (idx_q == SLOT_MAX) slot = idx_q;
      else                       slot = idx_q + 1'b1;
   end

   always_comb begin
      hit   = 1'b0;
      right = lr_bit;
      old   = 1'b0;
      case (cfg.fmt)
         FMT_LJ:  hit = (slot == wl_s - 1'b1);
         FMT_I2S: hit = (slot == wl_s);
         FMT_RJ: begin
            hit   = marker;
            right = lr_prev;
            old   = 1'b1;
         end
         default: begin
            hit   = (slot == wl_s) || (slot == wl2_s);
            right = (slot == wl2_s);
         end
      endcase
   end

   assign cap_en    = hit & bit_stb & synced & ~busy_o;
   assign cap_right = right;
   assign cap_old   = old;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lr_prev    <= 1'b0;
         idx_q      <= '0;
         synced     <= 1'b0;
         left_seen  <= 1'b0;
         rise_cnt   <= '0;
         busy_o     <= 1'b1;
         frame_done <= 1'b0;
      end else begin
         frame_done <= cap_en & right & left_seen;
         if (bit_stb) begin
            lr_prev <= lr_bit;
            idx_q   <= slot;
         end
         if (mode_chg) begin
            synced    <= 1'b0;
            busy_o    <= 1'b1;
            rise_cnt  <= '0;
            left_seen <= 1'b0;
         end else begin
            if (marker) synced <= 1'b1;
            if (busy_o && lr_rise) begin
               if (rise_cnt == RCNT_W'(RISES_NEED - 1)) busy_o <= 1'b0;
               else rise_cnt <= rise_cnt + 1'b1;
            end
            if (cap_en) left_seen <= ~right;
         end
      end
   end

endmodule

// File: rtl/sar_lane.sv
module sar_lane
   import sar_pkg::*;
#(
   parameter int OUT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_stb,
   input  logic             din,
   input  logic             cap_en,
   input  logic             cap_right,
   input  logic             cap_old,
   input  logic [4:0]       wlen,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o
);

   logic [MAX_WORD-1:0] sh, word;
   logic [OUT_W-1:0]    ext;

   assign word = cap_old ? sh : {sh[MAX_WORD-2:0], din};

   always_comb begin
      for (int i = 0; i < OUT_W; i++) begin
         if (i < int'(wlen)) ext[i] = word[i];
         else                ext[i] = word[wlen - 5'd1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh      <= '0;
         left_o  <= '0;
         right_o <= '0;
      end else begin
         if (bit_stb) sh <= {sh[MAX_WORD-2:0], din};
         if (cap_en) begin
            if (cap_right) right_o <= ext;
            else           left_o  <= ext;
         end
      end
   end

endmodule

// File: rtl/sar_rx.sv
module sar_rx
   import sar_pkg::*;
#(
   parameter int LANES  = 3,
   parameter int OUT_W  = 24,
   parameter int SLOT_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [2:0]               mode_i,
   input  logic                     bclk_i,
   input  logic                     lrclk_i,
   input  logic [LANES-1:0]         sdata_i,
   output logic [2*LANES*OUT_W-1:0] sample_o,
   output logic                     valid_o
);

   localparam int NCH = 2 * LANES;

   if (LANES < 1)            begin : g_bad_lanes  $error("LANES must be at least 1");  end
   if (OUT_W < MAX_WORD)     begin : g_bad_width  $error("OUT_W below word width");     end
   if (SLOT_W < 6)           begin : g_bad_slot   $error("SLOT_W too small for 33 slots"); end

   logic [2:0]           mode_q;
   logic                 mode_chg, rcv_busy;
   cfg_t                 cfg;
   logic                 bit_stb, lr_bit;
   logic [LANES-1:0]     dat_bit;
   logic                 cap_en, cap_right, cap_old, frame_done;
   logic [NCH*OUT_W-1:0] stage_all;

   assign cfg      = decode_mode(mode_i);
   assign mode_chg = (mode_i != mode_q);

   always_ff @(posedge clk) begin
      if (!rst_n) mode_q <= mode_i;
      else        mode_q <= mode_i;
   end

   sar_edge #(.LANES(LANES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_i  (bclk_i),
      .lrclk_i (lrclk_i),
      .sdata_i (sdata_i),
      .bit_stb (bit_stb),
      .lr_bit  (lr_bit),
      .dat_bit (dat_bit)
   );

   sar_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_stb    (bit_stb),
      .lr_bit     (lr_bit),
      .cfg        (cfg),
      .mode_chg   (mode_chg),
      .cap_en     (cap_en),
      .cap_right  (cap_right),
      .cap_old    (cap_old),
      .frame_done (frame_done),
      .busy_o     (rcv_busy)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      sar_lane #(.OUT_W(OUT_W)) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .bit_stb   (bit_stb),
         .din       (dat_bit[g]),
         .cap_en    (cap_en),
         .cap_right (cap_right),
         .cap_old   (cap_old),
         .wlen      (cfg.wlen),
         .left_o    (stage_all[(2*g)*OUT_W +: OUT_W]),
         .right_o   (stage_all[(2*g+1)*OUT_W +: OUT_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sample_o <= '0;
         valid_o  <= 1'b0;
      end else if (mode_chg || rcv_busy) begin
         sample_o <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= frame_done;
         if (frame_done) sample_o <= stage_all;
      end
   end

endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk #(
   parameter int LANES = 3,
   parameter int OUT_W = 24
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [2:0]               mode_i,
   input logic                     valid_o,
   input logic [2*LANES*OUT_W-1:0] sample_o,
   input logic                     busy
);

   assert_mute_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (sample_o == '0 && !valid_o));

   assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != $past(mode_i)) |=> busy);

   assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && !busy && !$past(busy)) |-> $stable(sample_o));

endmodule

bind sar_rx sar_rx_chk #(.LANES(LANES), .OUT_W(OUT_W)) u_sar_rx_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_i   (mode_i),
   .valid_o  (valid_o),
   .sample_o (sample_o),
   .busy     (rcv_busy)
);

// File: tb/test_sar_rx.sv
module test_sar_rx;

   localparam int LANES = 3;
   localparam int OUT_W = 24;
   localparam int NCH   = 2 * LANES;
   localparam int NVEC  = 13;
   // entry: [15:13] mode, [12:11] fmt (0 RJ,1 I2S,2 LJ,3 DSP), [10:6] word length, [5:0] bits per half
   localparam logic [15:0] VEC [NVEC] = '{
      {3'd0, 2'd0, 5'd16, 6'd32}, {3'd1, 2'd0, 5'd20, 6'd32}, {3'd2, 2'd0, 5'd24, 6'd32},
      {3'd3, 2'd1, 5'd16, 6'd32}, {3'd4, 2'd1, 5'd20, 6'd32}, {3'd5, 2'd1, 5'd24, 6'd32},
      {3'd6, 2'd2, 5'd24, 6'd32}, {3'd7, 2'd3, 5'd16, 6'd32}, {3'd2, 2'd0, 5'd24, 6'd24},
      {3'd6, 2'd2, 5'd24, 6'd24}, {3'd3, 2'd1, 5'd16, 6'd24}, {3'd7, 2'd3, 5'd16, 6'd24},
      {3'd4, 2'd1, 5'd20, 6'd24}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [2:0]           mode = 3'd0;
   logic                 bclk = 1'b0;
   logic                 lrclk = 1'b0;
   logic [LANES-1:0]     sdata = '0;
   logic [NCH*OUT_W-1:0] sample;
   logic                 valid;

   logic [23:0] samp [NCH];
   int          cur_fmt, cur_w, cur_b;
   string       cur_tag;
   int          errs = 0, checks = 0, vcount = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   sar_rx i_sar_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode),
      .bclk_i   (bclk),
      .lrclk_i  (lrclk),
      .sdata_i  (sdata),
      .sample_o (sample),
      .valid_o  (valid)
   );

   always @(negedge clk) if (valid) vcount++;

   task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic logic [23:0] sext(input logic [23:0] v, input int w);
      logic [23:0] r;
      for (int i = 0; i < 24; i++) r[i] = (i < w) ? v[i] : v[w-1];
      return r;
   endfunction

   function automatic logic [23:0] gen(input int v, input int c);
      logic [31:0] x;
      x = 32'(v * 6 + c + 1) * 32'h9E3779B1;
      x = x ^ (x >> 13);
      return x[27:4];
   endfunction

   function automatic logic tx_bit(input int fmt, input int w, input int b, input int pos,
                                   input logic [23:0] sl, input logic [23:0] sr);
      int h;
      logic [23:0] s;
      if (fmt == 3) begin
         if (pos >= 1 && pos <= w)     return sl[w-pos];
         if (pos > w && pos <= 2 * w)  return sr[2*w-pos];
         return 1'b1;
      end
      h = (pos < b) ? pos : pos - b;
      s = (pos < b) ? sl : sr;
      if (fmt == 2 && h < w)             return s[w-1-h];
      if (fmt == 1 && h >= 1 && h <= w)  return s[w-h];
      if (fmt == 0 && h >= b - w)        return s[b-1-h];
      return 1'b1;
   endfunction

   task automatic check_samples(input string tag);
      for (int c = 0; c < NCH; c++) begin
         check(sample[c*OUT_W +: OUT_W] == sext(samp[c], cur_w),
               $sformatf("%s ch%0d", tag, c), 32'(sample[c*OUT_W +: OUT_W]), 32'(sext(samp[c], cur_w)));
      end
   endtask

   // called at a falling clk edge; bit clock low 4 cycles then high 4 cycles
   task automatic send_bit(input logic lr, input logic [LANES-1:0] d, input bit chk);
      bclk = 1'b0; lrclk = lr; sdata = d;
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      if (chk) begin
         @(posedge clk); @(posedge clk); #1;
         check(valid == 1'b0, {cur_tag, " R10 early"}, 32'(valid), 32'd0);
         @(posedge clk); #1;
         check(valid == 1'b1, {cur_tag, " R10 due"}, 32'(valid), 32'd1);
         check_samples(cur_tag);
         @(posedge clk); #1;
         check(valid == 1'b0, {cur_tag, " R9 pulse"}, 32'(valid), 32'd0);
         @(negedge clk);
      end else begin
         repeat (4) @(negedge clk);
      end
   endtask

   task automatic send_frame(input bit chk);
      int cpos;
      logic lr;
      logic [LANES-1:0] d;
      case (cur_fmt)
         0:       cpos = 0;
         1:       cpos = cur_b + cur_w;
         2:       cpos = cur_b + cur_w - 1;
         default: cpos = 2 * cur_w;
      endcase
      for (int pos = 0; pos < 2 * cur_b; pos++) begin
         lr = (cur_fmt == 3) ? (pos == 0) : (pos >= cur_b);
         for (int l = 0; l < LANES; l++)
            d[l] = tx_bit(cur_fmt, cur_w, cur_b, pos, samp[2*l], samp[2*l+1]);
         send_bit(lr, d, chk && pos == cpos);
      end
   endtask

   task automatic load_vec(input int v, input int seed);
      mode    = VEC[v][15:13];
      cur_fmt = int'(VEC[v][12:11]);
      cur_w   = int'(VEC[v][10:6]);
      cur_b   = int'(VEC[v][5:0]);
      for (int c = 0; c < NCH; c++) samp[c] = gen(seed, c);
      case (cur_fmt)
         0:       cur_tag = "R2/R5/R7/R8";
         1:       cur_tag = "R2/R4/R7/R8";
         2:       cur_tag = "R2/R3/R7/R8";
         default: cur_tag = "R2/R6/R7/R8";
      endcase
      cur_tag = $sformatf("%s%s mode%0d", cur_tag, (cur_b == 24) ? "/R12" : "", mode);
   endtask

   initial begin
      int vb;
      load_vec(0, 0);
      repeat (5) @(negedge clk);
      // R1: reset state
      check(valid == 1'b0, "R1 valid in reset", 32'(valid), 32'd0);
      check(sample == '0, "R1 samples in reset", 32'(sample[31:0]), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid == 1'b0 && sample == '0, "R1 after reset", 32'(valid), 32'd0);
      vb = vcount;
      send_frame(1'b0);
      send_frame(1'b0);
      check(vcount == vb, "R1 recovery after reset", 32'(vcount - vb), 32'd0);

      // vector table walk
      for (int v = 0; v < NVEC; v++) begin
         load_vec(v, v);
         repeat (4) send_frame(1'b0);
         vb = vcount;
         send_frame(1'b1);
         check(vcount - vb == 1, {cur_tag, " R9 one pulse per frame"}, 32'(vcount - vb), 32'd1);
         check_samples({cur_tag, " R9 hold"});
      end

      // R11: mode change mutes and resynchronizes
      load_vec(5, 40);
      @(posedge clk); #1;
      check(sample == '0, "R11 mute on change", 32'(sample[31:0]), 32'd0);
      check(valid == 1'b0, "R11 valid low on change", 32'(valid), 32'd0);
      @(negedge clk);
      vb = vcount;
      repeat (3) send_frame(1'b0);
      check(vcount == vb, "R11 no pulse in recovery", 32'(vcount - vb), 32'd0);
      check(sample == '0, "R11 muted through recovery", 32'(sample[31:0]), 32'd0);
      cur_tag = "R11 first frame";
      send_frame(1'b1);
      check(vcount - vb == 1, "R11 single pulse after recovery", 32'(vcount - vb), 32'd1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule